// File: doc/BRIEF.md
# Serial Control and Status Port with Latched Interrupt

This block lets a microprocessor configure a line transceiver and read its state over a byte-wide synchronous serial link. The host lowers a select line and gives eight serial clocks. During those clocks one control byte enters on the data input while one status byte leaves on the data output, most significant bit first in both directions. The control byte is held in an 8-bit register whose bits drive the transceiver's mode inputs. The status byte has two parts. Its upper five bits echo the matching control bits. Its lower three bits carry a sticky code-violation flag and two live line-status inputs.

A latched interrupt request pulls low whenever either live status input changes. The first serial clock of the next selected transfer releases it. The serial pins are asynchronous to the system clock. They pass through a two-stage synchroniser and an edge detector before any logic acts on them. Every full transfer overwrites the control register, so a host that only wants to poll must send the current control value again. A transfer cut short by deselection leaves the register untouched.

Top module: `csp_port`

## Requirements
- R1: After reset the control output is 0x00, the interrupt pull-down is inactive and the data output enable is low.
- R2: When the port is selected, the status byte is captured as {control[7:3], violation flag, loop_sync, sig_present}, from bit 7 down to bit 0. Bit 7 is presented first, and each following bit appears after a falling serial-clock edge.
- R3: Serial input is sampled on rising serial-clock edges, most significant bit first. The assembled byte is written to the control output after the eighth rising edge of the transfer.
- R4: If select is removed before eight rising edges, the control output keeps its previous value.
- R5: Rising edges beyond the eighth in one transfer are ignored. The control value is the first eight bits received.
- R6: A one-cycle pulse on code_viol sets a sticky flag (status bit 2). Every deselection clears the flag, including a select pulse with no clocks. If a set and a clear fall in the same cycle, the set wins.
- R7: A change on loop_sync or sig_present latches irq_pull high. A code_viol pulse never does.
- R8: The interrupt is released only by the first rising serial-clock edge of a selected transfer. A select pulse without clocks, and later rising edges of the same transfer, leave it latched.
- R9: Serial pins act on the third rising system-clock edge after they change. Status inputs act on the first. When a status change and the interrupt release land on the same edge, the interrupt stays latched.
- R10: sdo_en is high only while the port is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, asynchronous |
| sel_n | input | 1 | Active-low select that frames one transfer |
| sdi | input | 1 | Serial control data from the host |
| sdo | output | 1 | Serial status data to the host |
| sdo_en | output | 1 | Output enable for sdo; low means high impedance |
| irq_pull | output | 1 | High when the open-drain interrupt line is pulled low |
| loop_sync | input | 1 | Live loop in-sync indication |
| sig_present | input | 1 | Live line-signal-present indication |
| code_viol | input | 1 | One-cycle pulse per received line-code violation |
| ctrl | output | 8 | Control register driving the transceiver modes |

## Verification
Two functions can land on the same system-clock edge. One is the interrupt release from the first serial clock of a transfer. The other is a new status change that must set the interrupt again. The bench raises the serial clock and then toggles loop_sync after a delay of zero to four cycles. Using the stated latencies, it predicts whether the change falls before, on, or after the release edge. It then checks that irq_pull ends low only when the change came earlier, and stays high through a second serial clock of the same transfer.

// File: rtl/csp_pkg.sv
package csp_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LIVE_W = 3;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        byte_t rx;
        byte_t tx;
        cnt_t  cnt;
        logic  commit;
    } shift_st_t;

    typedef struct packed {
        logic viol;
        logic prev_sync;
        logic prev_sig;
        logic irq;
    } stat_st_t;
endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/csp_edge.sv
module csp_edge #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/csp_shifter.sv
module csp_shifter
    import csp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel_act,
    input  logic  sel_start,
    input  logic  sck_rise,
    input  logic  sck_fall,
    input  logic  sdi,
    input  byte_t load_val,
    output byte_t rx_byte,
    output logic  commit,
    output logic  sdo,
    output logic  first_rise,
    output cnt_t  bit_cnt
);
    localparam cnt_t LAST = cnt_t'(BYTE_W);

    shift_st_t q, d;

    always_comb begin
        d          = q;
        d.commit   = 1'b0;
        first_rise = 1'b0;
        if (sel_start) begin
            d.tx  = load_val;
            d.rx  = '0;
            d.cnt = '0;
        end else if (sel_act) begin
            if (sck_rise && (q.cnt < LAST)) begin
                d.rx       = {q.rx[BYTE_W-2:0], sdi};
                d.cnt      = q.cnt + 1'b1;
                d.commit   = (q.cnt == LAST - 1'b1);
                first_rise = (q.cnt == '0);
            end
            if (sck_fall && (q.cnt != '0) && (q.cnt < LAST)) begin
                d.tx = {q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_byte = q.rx;
    assign commit  = q.commit;
    assign sdo     = q.tx[BYTE_W-1];
    assign bit_cnt = q.cnt;
endmodule

// File: rtl/csp_status.sv
module csp_status
    import csp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loop_sync,
    input  logic sig_present,
    input  logic code_viol,
    input  logic clear,
    input  logic release_irq,
    output logic viol,
    output logic irq
);
    stat_st_t q, d;
    logic     changed;

    always_comb begin
        d           = q;
        changed     = (loop_sync ^ q.prev_sync) | (sig_present ^ q.prev_sig);
        d.prev_sync = loop_sync;
        d.prev_sig  = sig_present;
        d.viol      = code_viol | (q.viol & ~clear);
        d.irq       = changed | (q.irq & ~release_irq);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign viol = q.viol;
    assign irq  = q.irq;
endmodule

// File: rtl/csp_port.sv
module csp_port
    import csp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sel_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_en,
    output logic              irq_pull,
    input  logic              loop_sync,
    input  logic              sig_present,
    input  logic              code_viol,
    output logic [BYTE_W-1:0] ctrl
);
    logic [2:0] pin_lvl;
    logic [1:0] pin_rise, pin_fall;
    logic       sck_rise, sck_fall, sel_act, sel_start, sel_end, sdi_s;
    logic       commit, first_rise, viol;
    byte_t      rx_byte, status_byte, ctrl_d, ctrl_q;
    cnt_t       bit_cnt;

    csp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({sdi, ~sel_n, sck}), .dout(pin_lvl)
    );

    csp_edge #(.WIDTH(2)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl(pin_lvl[1:0]), .rise(pin_rise), .fall(pin_fall)
    );

    assign sck_rise  = pin_rise[0];
    assign sck_fall  = pin_fall[0];
    assign sel_start = pin_rise[1];
    assign sel_end   = pin_fall[1];
    assign sel_act   = pin_lvl[1];
    assign sdi_s     = pin_lvl[2];

    assign status_byte = {ctrl_q[BYTE_W-1:LIVE_W], viol, loop_sync, sig_present};

    csp_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .sel_act(sel_act), .sel_start(sel_start),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi(sdi_s),
        .load_val(status_byte), .rx_byte(rx_byte), .commit(commit),
        .sdo(sdo), .first_rise(first_rise), .bit_cnt(bit_cnt)
    );

    csp_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .loop_sync(loop_sync), .sig_present(sig_present), .code_viol(code_viol),
        .clear(sel_end), .release_irq(first_rise),
        .viol(viol), .irq(irq_pull)
    );

    always_comb begin
        ctrl_d = commit ? rx_byte : ctrl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl   = ctrl_q;
    assign sdo_en = sel_act;
endmodule

// File: rtl/csp_port_chk.sv
module csp_port_chk
    import csp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        sel_n,
    input logic        sdo_en,
    input logic        irq_pull,
    input logic        loop_sync,
    input logic        sig_present,
    input logic [BYTE_W-1:0] ctrl,
    input logic        commit,
    input logic        first_rise,
    input logic        sel_end,
    input logic        viol,
    input logic [CNT_W-1:0] bit_cnt
);
    logic last_sync, last_sig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_sync <= 1'b0;
            last_sig  <= 1'b0;
        end else begin
            last_sync <= loop_sync;
            last_sig  <= sig_present;
        end
    end

    assert_ctrl_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> $past(commit));

    assert_commit_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(sdo_en));

    assert_bitcnt_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BYTE_W));

    assert_viol_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(viol) |-> $past(sel_end));

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull) |-> $past((loop_sync != last_sync) || (sig_present != last_sig)));

    assert_irq_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pull) |-> $past(first_rise));

    assert_sdoen_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> !$past(sel_n));
endmodule

bind csp_port csp_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sdo_en(sdo_en),
    .irq_pull(irq_pull), .loop_sync(loop_sync), .sig_present(sig_present),
    .ctrl(ctrl), .commit(commit), .first_rise(first_rise),
    .sel_end(sel_end), .viol(viol), .bit_cnt(bit_cnt)
);

// File: tb/tb_csp_port.sv
module tb_csp_port;
    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sel_n = 1'b1, sdi = 1'b0;
    logic loop_sync = 1'b0, sig_present = 1'b0, code_viol = 1'b0;
    logic sdo, sdo_en, irq_pull;
    logic [7:0] ctrl;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$], act_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    csp_port dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sel_n(sel_n), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .irq_pull(irq_pull),
        .loop_sync(loop_sync), .sig_present(sig_present), .code_viol(code_viol),
        .ctrl(ctrl)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: pushes the expected status byte, then the byte captured from sdo
    task automatic xfer(input logic [7:0] tx, input logic [7:0] exp, input int nbits, input string req);
        logic [7:0] got;
        got = '0;
        if (nbits >= 8) begin
            exp_q.push_back(exp);
            tag_q.push_back(req);
        end
        sel_n = 1'b0;
        nclk(6);
        for (int i = 0; i < nbits; i++) begin
            if (i < 8) sdi = tx[7-i];
            else       sdi = 1'b1;
            nclk(6);
            if (i < 8) got[7-i] = sdo;
            if (i == 0) check(sdo_en == 1'b1, "R10", sdo_en, 1);
            sck = 1'b1;
            nclk(6);
            sck = 1'b0;
        end
        nclk(6);
        sel_n = 1'b1;
        nclk(8);
        if (nbits >= 8) act_q.push_back(got);
    endtask

    // interrupt release versus new status change, k cycles after the rising sck
    task automatic irq_race(input int k);
        logic exp_irq;
        logic [7:0] ctrl_before;
        ctrl_before = ctrl;
        exp_irq = (k >= 2);
        sig_present = ~sig_present;
        nclk(3);
        check(irq_pull == 1'b1, "R7", irq_pull, 1);
        sel_n = 1'b0;
        nclk(6);
        sck = 1'b1;
        nclk(k);
        loop_sync = ~loop_sync;
        nclk(8 - k);
        check(irq_pull == exp_irq, "R9", irq_pull, exp_irq);
        sck = 1'b0;
        nclk(6);
        sck = 1'b1;
        nclk(8);
        check(irq_pull == exp_irq, "R8", irq_pull, exp_irq);
        sck = 1'b0;
        nclk(6);
        sel_n = 1'b1;
        nclk(8);
        check(ctrl == ctrl_before, "R4", ctrl, ctrl_before);
    endtask

    // monitor: compares captured status bytes with the expected queue
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                logic [7:0] a, e;
                string r;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                r = tag_q.pop_front();
                check(a == e, r, a, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        nclk(3);
        check(ctrl == 8'h00, "R1", ctrl, 0);
        check(irq_pull == 1'b0, "R1", irq_pull, 0);
        check(sdo_en == 1'b0, "R1", sdo_en, 0);
        rst_n = 1'b1;
        nclk(2);

        xfer(8'hA5, 8'h00, 8, "R2");
        check(ctrl == 8'hA5, "R3", ctrl, 8'hA5);
        xfer(8'h3C, 8'hA0, 8, "R2");
        check(ctrl == 8'h3C, "R3", ctrl, 8'h3C);

        loop_sync = 1'b1;
        nclk(2);
        check(irq_pull == 1'b1, "R7", irq_pull, 1);
        xfer(8'h3C, 8'h3A, 8, "R2");
        check(irq_pull == 1'b0, "R8", irq_pull, 0);

        code_viol = 1'b1; nclk(1); code_viol = 1'b0; nclk(3);
        check(irq_pull == 1'b0, "R7", irq_pull, 0);
        xfer(8'h3C, 8'h3E, 8, "R6");
        xfer(8'h3C, 8'h3A, 8, "R6");

        code_viol = 1'b1; nclk(1); code_viol = 1'b0; nclk(3);
        xfer(8'h00, 8'h00, 0, "R6");
        xfer(8'h3C, 8'h3A, 8, "R6");

        sig_present = 1'b1;
        nclk(2);
        check(irq_pull == 1'b1, "R7", irq_pull, 1);
        xfer(8'h00, 8'h00, 0, "R8");
        check(irq_pull == 1'b1, "R8", irq_pull, 1);
        xfer(8'h3C, 8'h3B, 8, "R2");
        check(irq_pull == 1'b0, "R8", irq_pull, 0);

        xfer(8'hFF, 8'h00, 5, "R4");
        check(ctrl == 8'h3C, "R4", ctrl, 8'h3C);

        xfer(8'h81, 8'h3B, 10, "R5");
        check(ctrl == 8'h81, "R5", ctrl, 8'h81);
        check(sdo_en == 1'b0, "R10", sdo_en, 0);

        for (int k = 0; k <= 4; k++) irq_race(k);

        nclk(4);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule